// File: doc/BRIEF.md
# EEPROM Write-Enable and Commit Controller

This block sits behind the serial front end of a small EEPROM and decides whether a write sequence turns into a real update of the storage array or of the protection bits in the status register. The front end hands it one-cycle events: a decoded instruction, a received address, each received data byte, and the rise of chip select together with how many bits of the current byte had been clocked in when chip select rose. The controller buffers the bytes of a page write and tracks the write-enable latch. It applies the framing rules at the chip-select rise and then commits the write or drops it.

A committed array write is drained from the page buffer into the array, one buffer slot per clock, through a simple write port. Only the slots that received data are written. A committed status write stores two protection bits. After either kind of commit, a write-in-progress flag stays high for a fixed, parameterised number of cycles. While it is high, every new instruction is dropped.

Top module: `eeprom_wcommit`

## Requirements
- R1: After a synchronous reset, the write-enable latch, the write-in-progress flag and the protection bits are 0, `status_o` is 0 and `mem_we` is low.
- R2: Instruction codes on `op_kind` are: 1 set write enable, 2 clear write enable, 3 array write, 4 status write, 5 status read, 6 array read. A set-enable instruction sets the latch only if chip select rises with `bit_cnt` = 0 and no address or data event came after the instruction. Otherwise the latch keeps its value.
- R3: A clear-enable instruction clears the latch under the same framing rule as R2.
- R4: An array write commits only when all of the following hold at the chip-select rise: the latch is 1, an address was received, at least one data byte was received, and `bit_cnt` = 0. If any of these fails, no array write happens and the latch is unchanged.
- R5: Data bytes go to consecutive positions of the 16-byte page that holds the address, starting at the address's low four bits. After position 15 they wrap to position 0 of the same page, and a later byte overwrites an earlier one.
- R6: A committed page write changes only the positions that received data. All other array bytes keep their values.
- R7: A committed status write stores bits 3:2 of the last data byte as the protection bits. The other bits of that byte have no effect.
- R8: Every commit raises write-in-progress for exactly `WIP_CYCLES` cycles. `status_o` is {4'b0, protection[1:0], latch, write-in-progress}.
- R9: Every committed array or status write clears the write-enable latch.
- R10: While write-in-progress is 1, every instruction has no effect. This includes an instruction that arrives in the same cycle in which write-in-progress falls.
- R11: `mem_we` is asserted only while write-in-progress is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | One-cycle pulse: an instruction was decoded |
| op_kind | input | 3 | Decoded instruction code (see R2) |
| addr_valid | input | 1 | One-cycle pulse: the address was received |
| addr_in | input | ADDR_W | Byte address |
| data_valid | input | 1 | One-cycle pulse: a data byte was received |
| data_in | input | 8 | Received data byte |
| cs_rise | input | 1 | One-cycle pulse: chip select went high |
| bit_cnt | input | 3 | Bits of the current byte received when chip select rose |
| wel_o | output | 1 | Write-enable latch |
| wip_o | output | 1 | Write in progress |
| status_o | output | 8 | Status byte |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | ADDR_W | Array write address |
| mem_wdata | output | 8 | Array write data |

## Verification
Two functions can fall in the same clock edge: the busy timer expiring, and the decode of a new instruction. The bench waits until its own model shows one busy cycle left. It then presents a set-enable instruction on exactly the edge where write-in-progress drops, followed by a clean chip-select rise. The instruction must be dropped, so the latch must stay 0 afterwards. The model compares the latch, the busy flag and the status byte with the design on every clock.

// File: rtl/eewc_pkg.sv
// Package: shared instruction codes for the write commit controller.
// Assumes the front end encodes each instruction as one of these codes.
package eewc_pkg;
    typedef enum logic [2:0] {
        OPK_NONE    = 3'd0,
        OPK_WEN_SET = 3'd1,
        OPK_WEN_CLR = 3'd2,
        OPK_ARR_WR  = 3'd3,
        OPK_STAT_WR = 3'd4,
        OPK_STAT_RD = 3'd5,
        OPK_ARR_RD  = 3'd6,
        OPK_OTHER   = 3'd7
    } opk_t;
endpackage

// File: rtl/eewc_frame.sv
// Frame tracker: remembers which instruction opened the current chip-select
// frame and which events followed it. At the chip-select rise it issues the
// latch and commit pulses that the framing rules allow.
// Assumes at most one front-end event per cycle.
module eewc_frame
    import eewc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       op_valid,
    input  logic [2:0] op_kind,
    input  logic       addr_valid,
    input  logic       data_valid,
    input  logic       cs_rise,
    input  logic [2:0] bit_cnt,
    input  logic       wel,
    input  logic       wip,
    output logic       set_wel,
    output logic       clr_wel,
    output logic       commit_arr,
    output logic       commit_sr,
    output logic       buf_load,
    output logic       buf_byte,
    output logic       sr_byte
);
    opk_t kind_q;
    logic extra_q;
    logic addr_seen_q;
    logic got_data_q;
    logic on_boundary;

    // Track the opening instruction and the events that followed it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q      <= OPK_NONE;
            extra_q     <= 1'b0;
            addr_seen_q <= 1'b0;
            got_data_q  <= 1'b0;
        end else if (cs_rise) begin
            kind_q <= OPK_NONE;
        end else if (op_valid) begin
            kind_q      <= wip ? OPK_NONE : opk_t'(op_kind);
            extra_q     <= 1'b0;
            addr_seen_q <= 1'b0;
            got_data_q  <= 1'b0;
        end else if (addr_valid) begin
            extra_q     <= 1'b1;
            addr_seen_q <= 1'b1;
        end else if (data_valid) begin
            extra_q    <= 1'b1;
            got_data_q <= 1'b1;
        end
    end

    // Evaluate the framing rules at the chip-select rise.
    always_comb begin
        on_boundary = cs_rise && (bit_cnt == 3'd0);
        set_wel     = on_boundary && (kind_q == OPK_WEN_SET) && !extra_q;
        clr_wel     = on_boundary && (kind_q == OPK_WEN_CLR) && !extra_q;
        commit_arr  = on_boundary && (kind_q == OPK_ARR_WR) && wel
                      && addr_seen_q && got_data_q;
        commit_sr   = on_boundary && (kind_q == OPK_STAT_WR) && wel && got_data_q;
        buf_load    = !cs_rise && !op_valid && addr_valid && (kind_q == OPK_ARR_WR);
        buf_byte    = !cs_rise && !op_valid && !addr_valid && data_valid
                      && (kind_q == OPK_ARR_WR) && addr_seen_q;
        sr_byte     = !cs_rise && !op_valid && !addr_valid && data_valid
                      && (kind_q == OPK_STAT_WR);
    end

    // R4: an array commit can only start while the device is idle.
    a_r4_commit_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        commit_arr |-> !wip);
endmodule

// File: rtl/eewc_page_buf.sv
// Page buffer: holds up to one page of write data with a valid mask.
// After a commit it drains every slot in order, one slot per cycle, and
// strobes the array write port only for slots that hold data.
// Assumes no new load arrives while a drain runs (instructions are dropped
// while busy).
module eewc_page_buf #(
    parameter int ADDR_W     = 9,
    parameter int PAGE_BYTES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              byte_wr,
    input  logic [7:0]        data_in,
    input  logic              drain_go,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata
);
    localparam int SLOT_W = $clog2(PAGE_BYTES);
    localparam int PAGE_W = ADDR_W - SLOT_W;
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(PAGE_BYTES - 1);

    logic [PAGE_W-1:0]     page_q;
    logic [SLOT_W-1:0]     ptr_q;
    logic [SLOT_W-1:0]     idx_q;
    logic                  drain_q;
    logic [PAGE_BYTES-1:0] vld_w;
    logic [7:0]            slot_w [PAGE_BYTES];

    // Latch the page and the start slot, then step the slot pointer per byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_q <= '0;
            ptr_q  <= '0;
        end else if (load) begin
            page_q <= addr_in[ADDR_W-1:SLOT_W];
            ptr_q  <= addr_in[SLOT_W-1:0];
        end else if (byte_wr) begin
            ptr_q <= ptr_q + 1'b1;
        end
    end

    // One storage slot per page position, with its own valid flag.
    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
        logic [7:0] d_q;
        logic       v_q;
        // Capture a byte aimed at this slot; a new address empties the slot.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                d_q <= '0;
                v_q <= 1'b0;
            end else if (load) begin
                v_q <= 1'b0;
            end else if (byte_wr && (ptr_q == SLOT_W'(g))) begin
                d_q <= data_in;
                v_q <= 1'b1;
            end
        end
        assign vld_w[g]  = v_q;
        assign slot_w[g] = d_q;
    end

    // Walk through all slots once after a commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drain_q <= 1'b0;
            idx_q   <= '0;
        end else if (drain_go) begin
            drain_q <= 1'b1;
            idx_q   <= '0;
        end else if (drain_q) begin
            idx_q <= idx_q + 1'b1;
            if (idx_q == LAST_SLOT) begin
                drain_q <= 1'b0;
            end
        end
    end

    // Present the current slot on the array write port.
    always_comb begin
        mem_we    = drain_q && vld_w[idx_q];
        mem_addr  = {page_q, idx_q};
        mem_wdata = slot_w[idx_q];
    end

    // R5: the write strobe stays inside the latched page.
    a_r5_strobe_in_page: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |-> (mem_addr[ADDR_W-1:SLOT_W] == $past(mem_addr[ADDR_W-1:SLOT_W])));
endmodule

// File: rtl/eewc_busy.sv
// Busy timer: holds the write-in-progress flag high for a fixed number of
// cycles after each commit.
// Assumes no new start arrives while busy.
module eewc_busy #(
    parameter int WIP_CYCLES = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic wip
);
    localparam int CNT_W = $clog2(WIP_CYCLES + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(WIP_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    // Load the count on start, then count down to zero and drop the flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wip   <= 1'b0;
            cnt_q <= '0;
        end else if (start) begin
            wip   <= 1'b1;
            cnt_q <= LOAD;
        end else if (wip) begin
            if (cnt_q == '0) begin
                wip <= 1'b0;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    // R8: a start is followed by a busy cycle.
    a_r8_start_sets_wip: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> wip);
    // R8: the count never exceeds the loaded window.
    a_r8_cnt_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        wip |-> (cnt_q <= LOAD));
endmodule

// File: rtl/eeprom_wcommit.sv
// Top level: write-enable latch, protection bits and status byte. It joins
// the frame tracker, the page buffer and the busy timer.
// Assumes one-cycle event pulses from the serial front end, at most one per
// cycle, and WIP_CYCLES no smaller than PAGE_BYTES.
module eeprom_wcommit
    import eewc_pkg::*;
#(
    parameter int ADDR_W     = 9,
    parameter int PAGE_BYTES = 16,
    parameter int WIP_CYCLES = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [2:0]        op_kind,
    input  logic              addr_valid,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              data_valid,
    input  logic [7:0]        data_in,
    input  logic              cs_rise,
    input  logic [2:0]        bit_cnt,
    output logic              wel_o,
    output logic              wip_o,
    output logic [7:0]        status_o,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata
);
    logic       set_wel, clr_wel, commit_arr, commit_sr;
    logic       buf_load, buf_byte, sr_byte;
    logic       wel_q;
    logic [1:0] prot_q;
    logic [1:0] sr_shadow_q;
    logic       wip;
    logic       commit_any;

    assign commit_any = commit_arr || commit_sr;

    eewc_frame u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_valid   (op_valid),
        .op_kind    (op_kind),
        .addr_valid (addr_valid),
        .data_valid (data_valid),
        .cs_rise    (cs_rise),
        .bit_cnt    (bit_cnt),
        .wel        (wel_q),
        .wip        (wip),
        .set_wel    (set_wel),
        .clr_wel    (clr_wel),
        .commit_arr (commit_arr),
        .commit_sr  (commit_sr),
        .buf_load   (buf_load),
        .buf_byte   (buf_byte),
        .sr_byte    (sr_byte)
    );

    eewc_page_buf #(
        .ADDR_W     (ADDR_W),
        .PAGE_BYTES (PAGE_BYTES)
    ) u_page (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (buf_load),
        .addr_in   (addr_in),
        .byte_wr   (buf_byte),
        .data_in   (data_in),
        .drain_go  (commit_arr),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata)
    );

    eewc_busy #(
        .WIP_CYCLES (WIP_CYCLES)
    ) u_busy (
        .clk   (clk),
        .rst_n (rst_n),
        .start (commit_any),
        .wip   (wip)
    );

    // Write-enable latch: commits clear it, framed instructions set or clear it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wel_q <= 1'b0;
        end else if (commit_any) begin
            wel_q <= 1'b0;
        end else if (set_wel) begin
            wel_q <= 1'b1;
        end else if (clr_wel) begin
            wel_q <= 1'b0;
        end
    end

    // Keep the protection field of the last status-write byte in the frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_shadow_q <= '0;
        end else if (sr_byte) begin
            sr_shadow_q <= data_in[3:2];
        end
    end

    // Store the protection bits on a committed status write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prot_q <= '0;
        end else if (commit_sr) begin
            prot_q <= sr_shadow_q;
        end
    end

    // Assemble the status byte.
    always_comb begin
        wel_o    = wel_q;
        wip_o    = wip;
        status_o = {4'b0000, prot_q, wel_q, wip};
    end

    // R9: a commit leaves the latch cleared.
    a_r9_commit_clears_wel: assert property (@(posedge clk) disable iff (!rst_n)
        commit_any |=> !wel_q);
    // R10: the latch does not move while busy.
    a_r10_wel_frozen_busy: assert property (@(posedge clk) disable iff (!rst_n)
        wip |=> $stable(wel_q));
    // R7: protection bits change only through a status commit.
    a_r7_prot_needs_commit: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_sr |=> $stable(prot_q));
    // R11: array strobes happen only inside the busy window.
    a_r11_we_inside_wip: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> wip);
endmodule

// File: tb/eeprom_wcommit_bench.sv
module eeprom_wcommit_bench;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 9;
    localparam int WIP_CYCLES = 40;
    localparam int MEM_N      = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              op_valid = 1'b0;
    logic [2:0]        op_kind = '0;
    logic              addr_valid = 1'b0;
    logic [ADDR_W-1:0] addr_in = '0;
    logic              data_valid = 1'b0;
    logic [7:0]        data_in = '0;
    logic              cs_rise = 1'b0;
    logic [2:0]        bit_cnt = '0;
    logic              wel_o, wip_o, mem_we;
    logic [7:0]        status_o, mem_wdata;
    logic [ADDR_W-1:0] mem_addr;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    eeprom_wcommit #(.ADDR_W(ADDR_W), .PAGE_BYTES(16), .WIP_CYCLES(WIP_CYCLES)) u_eeprom_wcommit (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
        .addr_valid(addr_valid), .addr_in(addr_in), .data_valid(data_valid),
        .data_in(data_in), .cs_rise(cs_rise), .bit_cnt(bit_cnt), .wel_o(wel_o),
        .wip_o(wip_o), .status_o(status_o), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata)
    );

    // Array written by the design, and the array the model expects.
    logic [7:0] arr [MEM_N];
    logic [7:0] exp_arr [MEM_N];
    initial begin
        for (int i = 0; i < MEM_N; i++) begin
            arr[i]     = 8'(i ^ 8'h5A);
            exp_arr[i] = 8'(i ^ 8'h5A);
        end
    end
    always @(posedge clk) if (mem_we) arr[mem_addr] <= mem_wdata;

    // Behavioural reference model.
    int  m_kind = 0, m_left = 0, m_ptr = 0, m_last = 0, m_prot = 0;
    bit  m_wel = 0, m_extra = 0, m_addr_seen = 0, m_got = 0;
    byte pend [int];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_kind = 0; m_left = 0; m_wel = 0; m_prot = 0;
            m_extra = 0; m_addr_seen = 0; m_got = 0;
            pend.delete();
        end else begin
            automatic bit busy = (m_left > 0);
            if (busy) m_left--;
            if (cs_rise) begin
                if (bit_cnt == 0) begin
                    if (m_kind == 1 && !m_extra) m_wel = 1;
                    else if (m_kind == 2 && !m_extra) m_wel = 0;
                    else if (m_kind == 3 && m_wel && m_addr_seen && m_got) begin
                        foreach (pend[k]) exp_arr[k] = pend[k];
                        m_left = WIP_CYCLES; m_wel = 0;
                    end else if (m_kind == 4 && m_wel && m_got) begin
                        m_prot = (m_last >> 2) & 3;
                        m_left = WIP_CYCLES; m_wel = 0;
                    end
                end
                m_kind = 0;
            end else if (op_valid) begin
                m_kind = busy ? 0 : int'(op_kind);
                m_extra = 0; m_addr_seen = 0; m_got = 0;
            end else if (addr_valid) begin
                m_extra = 1; m_addr_seen = 1;
                if (m_kind == 3) begin
                    pend.delete();
                    m_ptr = int'(addr_in);
                end
            end else if (data_valid) begin
                m_extra = 1; m_got = 1;
                if (m_kind == 3 && m_addr_seen) begin
                    pend[m_ptr] = byte'(data_in);
                    m_ptr = (m_ptr & 'h1F0) | ((m_ptr + 1) & 'hF);
                end
                if (m_kind == 4) m_last = int'(data_in);
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Compare against the model on every clock, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(wel_o == m_wel, "R2/R3/R9/R10 latch", wel_o, m_wel);
            chk(wip_o == (m_left > 0), "R8 busy flag", wip_o, m_left > 0);
            chk(status_o == 8'({m_prot[1:0], m_wel, m_left > 0}), "R8 status",
                status_o, {m_prot[1:0], m_wel, m_left > 0});
            chk(!(mem_we && !wip_o), "R11 strobe outside busy", mem_we, 0);
        end
    end

    // One event per cycle: drive at a falling edge, clear at the next.
    task automatic ev_op(input int k);
        op_valid = 1; op_kind = 3'(k); @(negedge clk); op_valid = 0;
    endtask
    task automatic ev_addr(input int a);
        addr_valid = 1; addr_in = ADDR_W'(a); @(negedge clk); addr_valid = 0;
    endtask
    task automatic ev_data(input int d);
        data_valid = 1; data_in = 8'(d); @(negedge clk); data_valid = 0;
    endtask
    task automatic ev_rise(input int b);
        cs_rise = 1; bit_cnt = 3'(b); @(negedge clk); cs_rise = 0; bit_cnt = 0;
    endtask
    task automatic wait_idle();
        while (wip_o || m_left > 0) @(negedge clk);
        @(negedge clk);
    endtask
    task automatic mem_chk(input string req);
        automatic int bad = -1;
        for (int i = 0; i < MEM_N; i++) if (bad < 0 && arr[i] !== exp_arr[i]) bad = i;
        if (bad < 0) chk(1, req, 0, 0);
        else chk(0, req, arr[bad], exp_arr[bad]);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(status_o == 0 && !wel_o && !wip_o && !mem_we, "R1 reset state", status_o, 0);
        rst_n = 1;
        @(negedge clk);

        // R4: array write with the latch clear is dropped.
        ev_op(3); ev_addr('h020); ev_data('h11); ev_rise(0);
        chk(!wip_o, "R4 no commit without latch", wip_o, 0);

        // R2: extra byte after set-enable, then a mid-byte rise, then clean.
        ev_op(1); ev_data('h00); ev_rise(0);
        chk(!wel_o, "R2 extra byte ignored", wel_o, 0);
        ev_op(1); ev_rise(3);
        chk(!wel_o, "R2 mid-byte rise ignored", wel_o, 0);
        ev_op(1); ev_rise(0);
        chk(wel_o, "R2 latch set", wel_o, 1);

        // R3: clear-enable.
        ev_op(2); ev_rise(0);
        chk(!wel_o, "R3 latch cleared", wel_o, 0);

        // R5/R6: three-byte write from slot 10.
        ev_op(1); ev_rise(0);
        ev_op(3); ev_addr('h01A); ev_data('hA1); ev_data('hA2); ev_data('hA3); ev_rise(0);
        chk(wip_o && !wel_o, "R9 commit clears latch", wel_o, 0);
        begin
            automatic int n = 0;
            while (wip_o) begin n++; @(negedge clk); end
            chk(n == WIP_CYCLES, "R8 busy length", n, WIP_CYCLES);
        end
        wait_idle();
        mem_chk("R6 only written slots change");

        // R5: twenty bytes from slot 14 wrap and overwrite.
        ev_op(1); ev_rise(0);
        ev_op(3); ev_addr('h13E);
        for (int i = 0; i < 20; i++) ev_data('h30 + i);
        ev_rise(0);
        wait_idle();
        mem_chk("R5 in-page wrap");

        // R4: bad bit count, and no data byte: both dropped, latch kept.
        ev_op(1); ev_rise(0);
        ev_op(3); ev_addr('h050); ev_data('hEE); ev_rise(5);
        chk(!wip_o && wel_o, "R4 mid-byte rise aborts", wel_o, 1);
        ev_op(3); ev_addr('h050); ev_rise(0);
        chk(!wip_o && wel_o, "R4 address only aborts", wel_o, 1);
        mem_chk("R4 array unchanged");

        // R7: status write, only bits 3:2 kept.
        ev_op(4); ev_data('hFF); ev_rise(0);
        wait_idle();
        chk(status_o == 8'h0C, "R7 protection from 0xFF", status_o, 8'h0C);
        ev_op(1); ev_rise(0);
        chk(status_o == 8'h0E, "R8 status layout", status_o, 8'h0E);
        ev_op(4); ev_data('hF4); ev_rise(0);

        // R10: instructions while busy are dropped.
        ev_op(1); ev_rise(0);
        chk(!wel_o, "R10 set-enable while busy", wel_o, 0);
        while (m_left != 1) @(negedge clk);
        ev_op(1); ev_rise(0);
        chk(!wip_o && !wel_o, "R10 instruction on busy-fall edge", wel_o, 0);
        chk(status_o == 8'h04, "R7 protection from 0xF4", status_o, 8'h04);

        // R1: reset in mid-frame returns everything to zero.
        ev_op(1); ev_rise(0);
        rst_n = 0; @(negedge clk); @(negedge clk);
        chk(status_o == 0, "R1 reset clears status", status_o, 0);
        rst_n = 1; @(negedge clk);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++; checks++;
            $display("FAIL watchdog actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule